// File: doc/BRIEF.md
# Mesh Turn-Model Route Computation

This unit picks the output port of one router in a two-dimensional mesh that has no wraparound links. A head flit brings destination coordinates, and the router supplies its own coordinates. The unit compares the two pairs and produces a one-hot port select: Local, East, West, North or South. The select is registered only on a cycle where the head-flit strobe is high. On every other cycle the previous route is held, so the rest of the flit train can reuse it.

Two routing policies are available through a mode input. The deterministic mode fully resolves the X offset before it takes any Y hop, so a given source and destination always produce the same path. The adaptive mode follows the west-first turn model, in which every westward hop comes first. When a westward hop is not required, the unit may choose between the productive East and North/South directions. It makes that choice by comparing per-direction congestion hints. Neither mode can turn into West after travelling North or South, so the network stays free of cyclic channel dependencies.

North means increasing Y and East means increasing X. Coordinates are unsigned and sized as ceil(log2(K)) bits for K nodes per dimension.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first captured head flit, `port_sel` is 5'b00000.
- R2: The encoding of `port_sel` is bit0 Local, bit1 East, bit2 West, bit3 North and bit4 South. After a head flit is captured, exactly one bit is set.
- R3: While `head_vld` is low, `port_sel` keeps its value, whatever the coordinate, mode and hint inputs do.
- R4: A head flit presented with `head_vld` high on a rising edge is reflected in `port_sel` immediately after that edge.
- R5: When the destination equals the current node in both coordinates, Local is selected in either mode.
- R6: With `mode_adapt` = 0 and the X coordinates differing, the select is East if dst_x > cur_x and West otherwise, regardless of the Y offset.
- R7: With `mode_adapt` = 0 and the X coordinates equal, the select is North if dst_y > cur_y and South if dst_y < cur_y. The hints have no effect in this mode.
- R8: With `mode_adapt` = 1 and dst_x < cur_x, the select is West, regardless of the Y offset and the hints.
- R9: With `mode_adapt` = 1, dst_x >= cur_x and only one of East or North/South productive, that single direction is selected.
- R10: With `mode_adapt` = 1 and both East and a Y direction productive, the direction with the strictly lower hint is selected. Equal hints select East.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld | input | 1 | Head-flit strobe; captures a new route |
| mode_adapt | input | 1 | 0 = dimension order, 1 = west-first adaptive |
| cur_x | input | CW | This router's X coordinate |
| cur_y | input | CW | This router's Y coordinate |
| dst_x | input | CW | Destination X from the head flit |
| dst_y | input | CW | Destination Y from the head flit |
| hint_e | input | HW | Congestion hint for East (higher = busier) |
| hint_n | input | HW | Congestion hint for North |
| hint_s | input | HW | Congestion hint for South |
| port_sel | output | 5 | One-hot output port {S,N,W,E,L} |

## Verification
The hardest case to reach is the adaptive tie-break. It needs the destination to lie strictly north-east or south-east, the mode set to west-first, and the East hint equal to or straddling the hint of the active Y direction. Uniformly random hints seldom produce exact ties. The stimulus therefore adds directed cases that set the two relevant hints equal, one apart in each direction, and at 0 and the maximum value. It then runs a random phase in which hints are drawn from a small range so that ties recur. Hold behaviour is covered by randomising every input while the strobe is low.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_WEST  = 3'd2,
    DIR_NORTH = 3'd3,
    DIR_SOUTH = 3'd4
  } dir_e;

  localparam int NPORT = 5;

  typedef struct packed {
    logic east;
    logic west;
    logic north;
    logic south;
  } offs_t;

endpackage

// File: rtl/mr_offset_cmp.sv
module mr_offset_cmp
  import mesh_route_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output offs_t         offs
);

  always_comb begin
    offs.east  = (dst_x > cur_x);
    offs.west  = (dst_x < cur_x);
    offs.north = (dst_y > cur_y);
    offs.south = (dst_y < cur_y);
  end

endmodule

// File: rtl/mr_dor_pick.sv
module mr_dor_pick
  import mesh_route_pkg::*;
(
  input  offs_t offs,
  output dir_e  dir
);

  always_comb begin
    if (offs.east)       dir = DIR_EAST;
    else if (offs.west)  dir = DIR_WEST;
    else if (offs.north) dir = DIR_NORTH;
    else if (offs.south) dir = DIR_SOUTH;
    else                 dir = DIR_LOCAL;
  end

endmodule

// File: rtl/mr_wf_pick.sv
module mr_wf_pick
  import mesh_route_pkg::*;
#(
  parameter int HW = 4
) (
  input  offs_t         offs,
  input  logic [HW-1:0] hint_e,
  input  logic [HW-1:0] hint_n,
  input  logic [HW-1:0] hint_s,
  output dir_e          dir
);

  logic          y_prod;
  dir_e          y_dir;
  logic [HW-1:0] y_hint;
  logic          y_wins;

  always_comb begin
    y_prod = offs.north | offs.south;
    y_dir  = offs.north ? DIR_NORTH : DIR_SOUTH;
    y_hint = offs.north ? hint_n : hint_s;
    y_wins = (y_hint < hint_e);
  end

  always_comb begin
    if (offs.west)                    dir = DIR_WEST;
    else if (offs.east && y_prod)     dir = y_wins ? y_dir : DIR_EAST;
    else if (offs.east)               dir = DIR_EAST;
    else if (y_prod)                  dir = y_dir;
    else                              dir = DIR_LOCAL;
  end

endmodule

// File: rtl/mr_route_reg.sv
module mr_route_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mesh_route_pkg::*;
#(
  parameter int K  = 8,
  parameter int HW = 4,
  localparam int CW = (K > 1) ? $clog2(K) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                head_vld,
  input  logic                mode_adapt,
  input  logic [CW-1:0]       cur_x,
  input  logic [CW-1:0]       cur_y,
  input  logic [CW-1:0]       dst_x,
  input  logic [CW-1:0]       dst_y,
  input  logic [HW-1:0]       hint_e,
  input  logic [HW-1:0]       hint_n,
  input  logic [HW-1:0]       hint_s,
  output logic [NPORT-1:0]    port_sel
);

  offs_t            offs;
  dir_e             dor_dir;
  dir_e             wf_dir;
  dir_e             pick_dir;
  logic [NPORT-1:0] pick_oh;

  mr_offset_cmp #(.CW(CW)) u_cmp (
    .cur_x (cur_x),
    .cur_y (cur_y),
    .dst_x (dst_x),
    .dst_y (dst_y),
    .offs  (offs)
  );

  mr_dor_pick u_dor (
    .offs (offs),
    .dir  (dor_dir)
  );

  mr_wf_pick #(.HW(HW)) u_wf (
    .offs   (offs),
    .hint_e (hint_e),
    .hint_n (hint_n),
    .hint_s (hint_s),
    .dir    (wf_dir)
  );

  always_comb pick_dir = mode_adapt ? wf_dir : dor_dir;

  for (genvar i = 0; i < NPORT; i++) begin : g_oh
    assign pick_oh[i] = (int'(pick_dir) == i);
  end

  mr_route_reg #(.W(NPORT)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (head_vld),
    .d     (pick_oh),
    .q     (port_sel)
  );

  AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld |=> $stable(port_sel)); // R3

  AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && cur_x == dst_x && cur_y == dst_y) |=> port_sel == 5'b00001); // R5

  AST_DOR_EAST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !mode_adapt && dst_x > cur_x) |=> port_sel == 5'b00010); // R6

  AST_DOR_Y_AFTER_X: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !mode_adapt && dst_x == cur_x && dst_y < cur_y) |=> port_sel == 5'b10000); // R7

  AST_WF_WEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && mode_adapt && dst_x < cur_x) |=> port_sel == 5'b00100); // R8

  AST_WF_TIE_EAST: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && mode_adapt && dst_x > cur_x && dst_y > cur_y && hint_n == hint_e)
      |=> port_sel == 5'b00010); // R10

endmodule

// File: tb/tb_mesh_route_unit.sv
module tb_mesh_route_unit;

  localparam int K  = 8;
  localparam int HW = 4;
  localparam int CW = $clog2(K);

  logic          clk;
  logic          rst_n;
  logic          head_vld;
  logic          mode_adapt;
  logic [CW-1:0] cur_x, cur_y, dst_x, dst_y;
  logic [HW-1:0] hint_e, hint_n, hint_s;
  logic [4:0]    port_sel;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  logic [4:0] exp_sel;
  string      exp_tag;

  mesh_route_unit #(.K(K), .HW(HW)) dut (
    .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .mode_adapt(mode_adapt),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .hint_e(hint_e), .hint_n(hint_n), .hint_s(hint_s), .port_sel(port_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: returns port index {0 L,1 E,2 W,3 N,4 S}
  function automatic int ref_port(bit m, int cx, int cy, int dx, int dy,
                                  int he, int hn, int hs, output string tag);
    int yp;
    int yh;
    if (cx == dx && cy == dy) begin tag = "R5"; return 0; end
    if (!m) begin
      if (dx != cx) begin tag = "R6"; return (dx > cx) ? 1 : 2; end
      tag = "R7";
      return (dy > cy) ? 3 : 4;
    end
    if (dx < cx) begin tag = "R8"; return 2; end
    yp = (dy > cy) ? 3 : ((dy < cy) ? 4 : 0);
    if (dx == cx) begin tag = "R9"; return yp; end
    if (yp == 0) begin tag = "R9"; return 1; end
    tag = "R10";
    yh = (yp == 3) ? hn : hs;
    return (yh < he) ? yp : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    string t;
    int    p;
    if (!rst_n) begin
      exp_sel <= 5'b0;
      exp_tag <= "R1";
    end else if (head_vld) begin
      p = ref_port(mode_adapt, int'(cur_x), int'(cur_y), int'(dst_x), int'(dst_y),
                   int'(hint_e), int'(hint_n), int'(hint_s), t);
      exp_sel <= 5'b00001 << p;
      exp_tag <= {"R4 ", t};
    end else begin
      exp_tag <= "R3";
    end
  end

  task automatic check_out();
    n_chk++;
    if (port_sel !== exp_sel) begin
      n_fail++;
      $display("FAIL %s: port_sel=%b expected=%b", exp_tag, port_sel, exp_sel);
    end
    if (exp_sel != 5'b0) begin
      n_chk++;
      if ($countones(port_sel) != 1) begin
        n_fail++;
        $display("FAIL R2: port_sel=%b expected exactly one bit set", port_sel);
      end
    end
  endtask

  task automatic step(bit hv, bit m, int cx, int cy, int dx, int dy,
                      int he, int hn, int hs);
    @(negedge clk);
    check_out();
    head_vld   = hv;
    mode_adapt = m;
    cur_x  = CW'(cx); cur_y  = CW'(cy);
    dst_x  = CW'(dx); dst_y  = CW'(dy);
    hint_e = HW'(he); hint_n = HW'(hn); hint_s = HW'(hs);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hmax;
    hmax = (1 << HW) - 1;
    rst_n = 1'b0;
    head_vld = 1'b0; mode_adapt = 1'b0;
    cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0;
    hint_e = '0; hint_n = '0; hint_s = '0;
    // R1: reset value while held, with strobe active
    step(1, 0, 0, 0, 3, 3, 0, 0, 0);
    step(1, 1, 5, 5, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    head_vld = 1'b0;
    // R1: still zero before first head
    step(0, 0, 1, 2, 3, 4, 1, 2, 3);

    // R5 local in both modes, corners
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, K-1, K-1, K-1, K-1, 3, 2, 1);
    // R6 X first regardless of Y, corners
    step(1, 0, 0, 0, K-1, K-1, 0, 0, 0);
    step(1, 0, K-1, 0, 0, K-1, 0, 0, 0);
    // R7 Y after X, hints irrelevant
    step(1, 0, 3, 3, 3, K-1, 0, hmax, hmax);
    step(1, 0, 3, 3, 3, 0, 0, hmax, hmax);
    // R8 west only regardless of hints
    step(1, 1, K-1, 0, 0, K-1, hmax, 0, 0);
    step(1, 1, 4, 4, 3, 0, hmax, 0, 0);
    // R9 single productive
    step(1, 1, 2, 2, 2, 6, 0, hmax, 0);
    step(1, 1, 2, 6, 2, 1, 0, 0, hmax);
    step(1, 1, 2, 2, 6, 2, hmax, 0, 0);
    // R10 hint compare and ties
    step(1, 1, 1, 1, 5, 5, 4, 4, 0);
    step(1, 1, 1, 1, 5, 5, 4, 3, hmax);
    step(1, 1, 1, 1, 5, 5, 3, 4, 0);
    step(1, 1, 1, 6, 5, 2, 7, 0, 7);
    step(1, 1, 1, 6, 5, 2, 6, 0, 7);
    step(1, 1, 1, 6, 5, 2, 0, hmax, 0);
    step(1, 1, 0, 0, K-1, K-1, hmax, hmax, 0);
    step(1, 1, 0, 0, K-1, K-1, hmax, hmax - 1, 0);
    // R3 hold with everything changing
    for (int i = 0; i < 6; i++)
      step(0, i % 2, i, 7 - i, 7 - i, i, i, 15 - i, i);

    // random phase, narrow hint range so ties recur
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 2,
           $urandom % K, $urandom % K, $urandom % K, $urandom % K,
           $urandom % 3, $urandom % 3, $urandom % 3);

    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_out();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule